// File: doc/BRIEF.md
# Portal Call Sequencer

This controller carries out a call into another protection domain without switching tasks. The pipeline starts it when the target of a call lies in a region that carries portal rights. The block reads the one-line descriptor found at the call target and hands the caller's domain ID and its three well-known region registers to the register file for safekeeping. It then writes the caller's stack state to that caller's info slot. Next it reads the info slot that belongs to the destination domain and the current thread, loads the new domain state into the register file, and finishes with a normal call to the descriptor's entry address.

Stack memory and stack-state slots are never allocated. They are found by address arithmetic on the (domain, thread) pair. Stacklets occupy the top of the address space: the region base is all ones shifted left by `TURF_W+THREAD_W+STACKLET_SHIFT`. The info slots sit in an array just below that region, one cache line per pair. If the info line read back is all zero, the stacklet is treated as new and empty.

Memory traffic uses a single cache-line request/response port. Reads get a response, with an error flag. Writes are posted and get no response. The states are IDLE, DESC_REQ (descriptor read issued), DESC_WAIT (descriptor response awaited), SAVE (caller state handed out), INFO_WR (outgoing stack state written), INFO_RD (incoming slot read issued), INFO_WAIT (slot response awaited), LOAD (new state handed in), CALL (entry address issued) and FAULT (abort reported). The transitions are:
- IDLE→DESC_REQ on a start.
- DESC_REQ→DESC_WAIT when the request is accepted.
- DESC_WAIT→SAVE on a clean response, or DESC_WAIT→FAULT on an error response.
- SAVE→INFO_WR always.
- INFO_WR→INFO_RD when the write is accepted.
- INFO_RD→INFO_WAIT when the read is accepted.
- INFO_WAIT→LOAD on a clean response, or INFO_WAIT→FAULT on an error response.
- LOAD→CALL, CALL→IDLE and FAULT→IDLE always.

Top module: `portal_call_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `mem_req_valid`, `save_valid`, `load_valid`, `call_done` and `call_fault` are all 0.
- R2: The first request after a start is a read (`mem_req_write`=0) at the address given on `call_target`.
- R3: After a clean descriptor response, `save_valid` pulses for one cycle. During that pulse `save_turf` and `save_wk` carry the caller's domain ID and well-known registers as captured at the start. The pulse comes before the outgoing write is issued.
- R4: The second request is a write to `INFO_REGION + ({cur_turf,cur_thread} << 6)`, where `INFO_REGION` is the stacklet region base minus 2^(TURF_W+THREAD_W+6). Its data holds the caller's stack state zero-extended: top in bits [63:0], base in [127:64], limit in [191:128].
- R5: The third request is a read at the info slot of the pair (descriptor domain ID, `cur_thread`). It is issued in the cycle right after the write is accepted.
- R6: Descriptor line layout: entry address in [63:0], code register in [127:64], constant-data register in [191:128], data register in [255:192], domain ID in [263:256]. All other bits are ignored. During `load_valid`, `load_turf` and `load_wk` (code, constant, data from the low word up) come from the descriptor. `load_stack` is the info line's three fields when that line is non-zero.
- R7: An all-zero info line gives an empty stack. Both top and base equal the stacklet base `STACK_REGION + ({turf,thread} << 13)` and the limit equals that base plus 2^13.
- R8: `call_done` pulses for exactly one cycle, in the cycle after `load_valid`, with `call_entry` equal to the descriptor's entry address. The block is idle in the next cycle.
- R9: An error response to the descriptor read raises `call_fault` for one cycle. No save, no further request, no load and no done follow.
- R10: An error response to the info read raises `call_fault` for one cycle, with no load and no done.
- R11: A request that is not accepted keeps `mem_req_valid`, `mem_req_addr` and `mem_req_write` unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_start | input | 1 | Start a portal call (taken only when idle) |
| call_target | input | ADDR_W | Address of the portal descriptor |
| cur_turf | input | TURF_W | Caller's domain ID |
| cur_thread | input | THREAD_W | Current thread ID |
| cur_wk | input | 3*ADDR_W | Caller's well-known registers {data, const, code} |
| cur_stack | input | 3*ADDR_W | Caller's stack state {limit, base, top} |
| busy | output | 1 | Sequence in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | ADDR_W | Line address |
| mem_req_wdata | output | LINE_W | Write line |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read response carries an error |
| mem_rsp_rdata | input | LINE_W | Read line |
| save_valid | output | 1 | Save caller state strobe |
| save_turf | output | TURF_W | Caller domain ID to save |
| save_wk | output | 3*ADDR_W | Caller well-known registers to save |
| load_valid | output | 1 | Load new state strobe |
| load_turf | output | TURF_W | New domain ID |
| load_wk | output | 3*ADDR_W | New well-known registers |
| load_stack | output | 3*ADDR_W | New stack state {limit, base, top} |
| call_done | output | 1 | Issue the normal call |
| call_entry | output | ADDR_W | Entry address of the call |
| call_fault | output | 1 | Sequence aborted on a memory error |

## Verification
The properties assume that responses arrive only for reads the block has issued and that none arrives while the block is not waiting. They also assume that `mem_req_ready` may drop at any time. The bench's memory model follows this. It holds each accepted read, returns exactly one response one or two cycles later, and toggles readiness at random. Starts are applied only while the block is idle. Error responses are injected on the descriptor read and on the info read separately, so that each abort path is taken on its own.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_SAVE,
        ST_INFO_WR,
        ST_INFO_RD,
        ST_INFO_WAIT,
        ST_LOAD,
        ST_CALL,
        ST_FAULT
    } pcs_state_e;

endpackage

// File: rtl/pcs_slot_addr.sv
// Address of the slot for a (domain, thread) pair in a table of
// power-of-two sized slots anchored at BASE.
module pcs_slot_addr #(
    parameter int ADDR_W   = 64,
    parameter int TURF_W   = 8,
    parameter int THREAD_W = 8,
    parameter int SHIFT    = 6,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic [TURF_W-1:0]   turf,
    input  logic [THREAD_W-1:0] thread,
    output logic [ADDR_W-1:0]   addr
);
    localparam int ID_W = TURF_W + THREAD_W;

    logic [ADDR_W-1:0] index;

    assign index = {{(ADDR_W-ID_W){1'b0}}, turf, thread};
    assign addr  = BASE + (index << SHIFT);
endmodule

// File: rtl/pcs_stack_resolve.sv
// Turns an incoming info line into stack state; an all-zero line means
// a fresh, empty stacklet at the slot base.
module pcs_stack_resolve #(
    parameter int ADDR_W = 64,
    parameter int LINE_W = 512,
    parameter int SHIFT  = 13
) (
    input  logic [LINE_W-1:0]   info_line,
    input  logic [ADDR_W-1:0]   slot_base,
    output logic [3*ADDR_W-1:0] stack,
    output logic                empty
);
    localparam logic [ADDR_W-1:0] SPAN = {{(ADDR_W-1){1'b0}}, 1'b1} << SHIFT;

    assign empty = ~|info_line;

    always_comb begin
        if (empty) begin
            stack = {slot_base + SPAN, slot_base, slot_base};
        end else begin
            stack = info_line[3*ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/portal_call_seq.sv
module portal_call_seq
    import pcs_pkg::*;
#(
    parameter int ADDR_W         = 64,
    parameter int TURF_W         = 8,
    parameter int THREAD_W       = 8,
    parameter int STACKLET_SHIFT = 13,
    parameter int LINE_W         = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  call_start,
    input  logic [ADDR_W-1:0]     call_target,
    input  logic [TURF_W-1:0]     cur_turf,
    input  logic [THREAD_W-1:0]   cur_thread,
    input  logic [3*ADDR_W-1:0]   cur_wk,
    input  logic [3*ADDR_W-1:0]   cur_stack,
    output logic                  busy,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [LINE_W-1:0]     mem_req_wdata,
    input  logic                  mem_rsp_valid,
    input  logic                  mem_rsp_err,
    input  logic [LINE_W-1:0]     mem_rsp_rdata,
    output logic                  save_valid,
    output logic [TURF_W-1:0]     save_turf,
    output logic [3*ADDR_W-1:0]   save_wk,
    output logic                  load_valid,
    output logic [TURF_W-1:0]     load_turf,
    output logic [3*ADDR_W-1:0]   load_wk,
    output logic [3*ADDR_W-1:0]   load_stack,
    output logic                  call_done,
    output logic [ADDR_W-1:0]     call_entry,
    output logic                  call_fault
);
    localparam int ID_W       = TURF_W + THREAD_W;
    localparam int LINE_SHIFT = $clog2(LINE_W / 8);
    localparam int WK_LO      = ADDR_W;
    localparam int TURF_LO    = 4 * ADDR_W;
    localparam logic [ADDR_W-1:0] STACK_REGION =
        {ADDR_W{1'b1}} << (ID_W + STACKLET_SHIFT);
    localparam logic [ADDR_W-1:0] INFO_REGION =
        STACK_REGION - ({{(ADDR_W-1){1'b0}}, 1'b1} << (ID_W + LINE_SHIFT));

    pcs_state_e state_q, state_d;

    logic [ADDR_W-1:0]   tgt_q;
    logic [TURF_W-1:0]   turf_q;
    logic [THREAD_W-1:0] thread_q;
    logic [3*ADDR_W-1:0] wk_q;
    logic [3*ADDR_W-1:0] stk_q;
    logic [ADDR_W-1:0]   entry_q;
    logic [TURF_W-1:0]   new_turf_q;
    logic [3*ADDR_W-1:0] new_wk_q;
    logic [3*ADDR_W-1:0] new_stk_q;

    logic [ADDR_W-1:0]   out_info_addr;
    logic [ADDR_W-1:0]   in_info_addr;
    logic [ADDR_W-1:0]   in_slot_base;
    logic [3*ADDR_W-1:0] resolved_stk;
    logic                info_empty;

    // Outgoing slot: caller's pair. Incoming slot and stacklet: new pair.
    pcs_slot_addr #(
        .ADDR_W(ADDR_W), .TURF_W(TURF_W), .THREAD_W(THREAD_W),
        .SHIFT(LINE_SHIFT), .BASE(INFO_REGION)
    ) u_out_info (
        .turf(turf_q), .thread(thread_q), .addr(out_info_addr)
    );

    pcs_slot_addr #(
        .ADDR_W(ADDR_W), .TURF_W(TURF_W), .THREAD_W(THREAD_W),
        .SHIFT(LINE_SHIFT), .BASE(INFO_REGION)
    ) u_in_info (
        .turf(new_turf_q), .thread(thread_q), .addr(in_info_addr)
    );

    pcs_slot_addr #(
        .ADDR_W(ADDR_W), .TURF_W(TURF_W), .THREAD_W(THREAD_W),
        .SHIFT(STACKLET_SHIFT), .BASE(STACK_REGION)
    ) u_in_slot (
        .turf(new_turf_q), .thread(thread_q), .addr(in_slot_base)
    );

    pcs_stack_resolve #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .SHIFT(STACKLET_SHIFT)
    ) u_resolve (
        .info_line(mem_rsp_rdata), .slot_base(in_slot_base),
        .stack(resolved_stk), .empty(info_empty)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (call_start)     state_d = ST_DESC_REQ;
            ST_DESC_REQ:  if (mem_req_ready)  state_d = ST_DESC_WAIT;
            ST_DESC_WAIT: if (mem_rsp_valid)  state_d = mem_rsp_err ? ST_FAULT : ST_SAVE;
            ST_SAVE:                          state_d = ST_INFO_WR;
            ST_INFO_WR:   if (mem_req_ready)  state_d = ST_INFO_RD;
            ST_INFO_RD:   if (mem_req_ready)  state_d = ST_INFO_WAIT;
            ST_INFO_WAIT: if (mem_rsp_valid)  state_d = mem_rsp_err ? ST_FAULT : ST_LOAD;
            ST_LOAD:                          state_d = ST_CALL;
            ST_CALL:                          state_d = ST_IDLE;
            ST_FAULT:                         state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State register and captured context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tgt_q      <= '0;
            turf_q     <= '0;
            thread_q   <= '0;
            wk_q       <= '0;
            stk_q      <= '0;
            entry_q    <= '0;
            new_turf_q <= '0;
            new_wk_q   <= '0;
            new_stk_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && call_start) begin
                tgt_q    <= call_target;
                turf_q   <= cur_turf;
                thread_q <= cur_thread;
                wk_q     <= cur_wk;
                stk_q    <= cur_stack;
            end
            if (state_q == ST_DESC_WAIT && mem_rsp_valid && !mem_rsp_err) begin
                entry_q    <= mem_rsp_rdata[ADDR_W-1:0];
                new_wk_q   <= mem_rsp_rdata[WK_LO +: 3*ADDR_W];
                new_turf_q <= mem_rsp_rdata[TURF_LO +: TURF_W];
            end
            if (state_q == ST_INFO_WAIT && mem_rsp_valid && !mem_rsp_err) begin
                new_stk_q <= resolved_stk;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        save_valid    = 1'b0;
        load_valid    = 1'b0;
        call_done     = 1'b0;
        call_fault    = 1'b0;
        unique case (state_q)
            ST_DESC_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tgt_q;
            end
            ST_SAVE:     save_valid = 1'b1;
            ST_INFO_WR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = out_info_addr;
                mem_req_wdata = LINE_W'(stk_q);
            end
            ST_INFO_RD: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = in_info_addr;
            end
            ST_LOAD:     load_valid = 1'b1;
            ST_CALL:     call_done  = 1'b1;
            ST_FAULT:    call_fault = 1'b1;
            default: ;
        endcase
    end

    assign save_turf  = turf_q;
    assign save_wk    = wk_q;
    assign load_turf  = new_turf_q;
    assign load_wk    = new_wk_q;
    assign load_stack = new_stk_q;
    assign call_entry = entry_q;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R5
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_req_write) |=>
        (mem_req_valid && !mem_req_write));

    // R3
    save_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_valid |=> (mem_req_valid && mem_req_write));

    // R8
    done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_done |-> $past(load_valid));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_done |=> !call_done);

    // R9
    desc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESC_WAIT && mem_rsp_valid && mem_rsp_err) |=>
        (call_fault && !save_valid && !mem_req_valid));

    // R10
    info_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INFO_WAIT && mem_rsp_valid && mem_rsp_err) |=>
        (call_fault && !load_valid));
endmodule

// File: tb/portal_call_seq_tb.sv
module portal_call_seq_tb;
    localparam int A  = 64;
    localparam int TW = 8;
    localparam int HW = 8;
    localparam int L  = 512;
    localparam logic [63:0] STK_REG  = 64'hFFFF_FFFF_E000_0000;
    localparam logic [63:0] INFO_REG = 64'hFFFF_FFFF_DFC0_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           call_start = 1'b0;
    logic [A-1:0]   call_target = '0;
    logic [TW-1:0]  cur_turf = '0;
    logic [HW-1:0]  cur_thread = '0;
    logic [3*A-1:0] cur_wk = '0;
    logic [3*A-1:0] cur_stack = '0;
    logic           busy;
    logic           mem_req_valid;
    logic           mem_req_ready = 1'b0;
    logic           mem_req_write;
    logic [A-1:0]   mem_req_addr;
    logic [L-1:0]   mem_req_wdata;
    logic           mem_rsp_valid = 1'b0;
    logic           mem_rsp_err = 1'b0;
    logic [L-1:0]   mem_rsp_rdata = '0;
    logic           save_valid;
    logic [TW-1:0]  save_turf;
    logic [3*A-1:0] save_wk;
    logic           load_valid;
    logic [TW-1:0]  load_turf;
    logic [3*A-1:0] load_wk;
    logic [3*A-1:0] load_stack;
    logic           call_done;
    logic [A-1:0]   call_entry;
    logic           call_fault;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 1'b0;

    always #5 clk = ~clk;

    portal_call_seq u_dut (
        .clk(clk), .rst_n(rst_n), .call_start(call_start),
        .call_target(call_target), .cur_turf(cur_turf), .cur_thread(cur_thread),
        .cur_wk(cur_wk), .cur_stack(cur_stack), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .save_valid(save_valid), .save_turf(save_turf), .save_wk(save_wk),
        .load_valid(load_valid), .load_turf(load_turf), .load_wk(load_wk),
        .load_stack(load_stack), .call_done(call_done), .call_entry(call_entry),
        .call_fault(call_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [L-1:0] act,
                       input logic [L-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [63:0] info_addr(logic [7:0] t, logic [7:0] h);
        return INFO_REG + ({48'd0, t, h} << 6);
    endfunction

    function automatic logic [63:0] slot_base(logic [7:0] t, logic [7:0] h);
        return STK_REG + ({48'd0, t, h} << 13);
    endfunction

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    // One portal call with a reactive memory model.
    task automatic do_call(input logic [7:0] turf, input logic [7:0] thread,
                           input logic [7:0] new_turf, input bit zero_info,
                           input bit desc_err, input bit info_err);
        logic [63:0]  target = rnd64() & ~64'h3F;
        logic [63:0]  entry  = rnd64();
        logic [191:0] wk     = {rnd64(), rnd64(), rnd64()};
        logic [191:0] nwk    = {rnd64(), rnd64(), rnd64()};
        logic [191:0] stk    = {rnd64(), rnd64(), rnd64()};
        logic [191:0] istk   = {rnd64(), rnd64(), rnd64()};
        logic [L-1:0] desc;
        logic [L-1:0] info;
        logic [L-1:0] rq_addr [4];
        bit           rq_wr [4];
        logic [L-1:0] wr_data = '0;
        int           nreq = 0, nrd = 0, pend = 0, cyc = 0;
        int           save_cyc = -1, wr_cyc = -1, load_cyc = -1, done_cyc = -1, fault_cyc = -1;
        logic [7:0]   sv_turf = '0, ld_turf = '0;
        logic [191:0] sv_wk = '0, ld_wk = '0, ld_stk = '0;
        logic [63:0]  entry_seen = '0;
        bit           hold_viol = 1'b0, held = 1'b0, fin = 1'b0, post_ok = 1'b1;
        logic [63:0]  held_addr = '0;
        bit           held_wr = 1'b0;
        logic [191:0] exp_stk;

        for (int w = 0; w < L / 32; w++) desc[w*32 +: 32] = $urandom();
        desc[255:0]   = {nwk, entry};
        desc[263:256] = new_turf;
        info = zero_info ? '0 : L'(istk);
        exp_stk = zero_info ? {slot_base(new_turf, thread) + 64'h2000,
                               slot_base(new_turf, thread), slot_base(new_turf, thread)}
                            : istk;

        @(negedge clk);
        call_target = target; cur_turf = turf; cur_thread = thread;
        cur_wk = wk; cur_stack = stk; call_start = 1'b1;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            cyc = c;
            call_start = 1'b0;
            cur_wk = '0; cur_stack = '0; cur_turf = ~turf;
            mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
            if (fin) begin
                post_ok = !call_done && !busy && !call_fault;
                break;
            end
            if (held && (!mem_req_valid || mem_req_addr != held_addr ||
                         mem_req_write != held_wr)) hold_viol = 1'b1;
            held = 1'b0;
            if (save_valid) begin save_cyc = c; sv_turf = save_turf; sv_wk = save_wk; end
            if (load_valid) begin load_cyc = c; ld_turf = load_turf; ld_wk = load_wk; ld_stk = load_stack; end
            if (call_done)  begin done_cyc = c; entry_seen = call_entry; fin = 1'b1; end
            if (call_fault) begin fault_cyc = c; fin = 1'b1; end
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = (nrd == 1) ? desc : info;
                    mem_rsp_err   = (nrd == 1) ? desc_err : info_err;
                end
            end
            mem_req_ready = ($urandom() % 3) != 0;
            if (mem_req_valid && mem_req_ready) begin
                if (nreq < 4) begin
                    rq_addr[nreq] = L'(mem_req_addr);
                    rq_wr[nreq]   = mem_req_write;
                end
                if (mem_req_write) begin wr_data = mem_req_wdata; wr_cyc = c; end
                else begin nrd++; pend = 1 + ($urandom() % 2); end
                nreq++;
            end else if (mem_req_valid) begin
                held = 1'b1; held_addr = mem_req_addr; held_wr = mem_req_write;
            end
        end
        mem_req_ready = 1'b0;

        chk(fin, "R8 sequence ends", L'(cyc), '0);
        chk(!hold_viol, "R11 request held while not accepted", L'(hold_viol), '0);
        chk(nreq >= 1 && !rq_wr[0] && rq_addr[0] == L'(target),
            "R2 descriptor read at target", rq_addr[0], L'(target));
        if (desc_err) begin
            chk(fault_cyc >= 0, "R9 fault raised", L'(fault_cyc), '0);
            chk(nreq == 1 && save_cyc < 0 && load_cyc < 0 && done_cyc < 0,
                "R9 no further action", L'(nreq), L'(1));
        end else begin
            chk(save_cyc >= 0 && sv_turf == turf && sv_wk == wk,
                "R3 save contents", L'({sv_turf, sv_wk}), L'({turf, wk}));
            chk(save_cyc >= 0 && wr_cyc > save_cyc, "R3 save before write",
                L'(save_cyc), L'(wr_cyc));
            chk(nreq == 3 && rq_wr[1] && rq_addr[1] == L'(info_addr(turf, thread)),
                "R4 outgoing info address", rq_addr[1], L'(info_addr(turf, thread)));
            chk(wr_data == L'(stk), "R4 outgoing info data", wr_data, L'(stk));
            chk(nreq == 3 && !rq_wr[2] && rq_addr[2] == L'(info_addr(new_turf, thread)),
                "R5 incoming info read", rq_addr[2], L'(info_addr(new_turf, thread)));
            if (info_err) begin
                chk(fault_cyc >= 0 && load_cyc < 0 && done_cyc < 0,
                    "R10 fault without load", L'(load_cyc), '0);
            end else begin
                chk(ld_turf == new_turf && ld_wk == nwk, "R6 load domain and regs",
                    L'({ld_turf, ld_wk}), L'({new_turf, nwk}));
                chk(ld_stk == exp_stk, zero_info ? "R7 empty stack default" : "R6 load stack",
                    L'(ld_stk), L'(exp_stk));
                chk(done_cyc == load_cyc + 1 && entry_seen == entry,
                    "R8 call after load with entry", L'(entry_seen), L'(entry));
                chk(post_ok, "R8 single pulse then idle", L'(post_ok), L'(1));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !mem_req_valid && !save_valid && !load_valid && !call_done && !call_fault,
            "R1 idle after reset",
            L'({busy, mem_req_valid, save_valid, load_valid, call_done, call_fault}), '0);

        // Directed corner cases
        do_call(8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);   // R7 empty, extreme IDs
        do_call(8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);   // R6
        do_call(8'h12, 8'h34, 8'h56, 1'b0, 1'b1, 1'b0);   // R9
        do_call(8'h9A, 8'hBC, 8'hDE, 1'b0, 1'b0, 1'b1);   // R10
        do_call(8'h01, 8'h80, 8'hFF, 1'b1, 1'b0, 1'b0);   // R7

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int k = $urandom() % 10;
            do_call(8'($urandom()), 8'($urandom()), 8'($urandom()),
                    ($urandom() % 4) == 0, k == 0, k == 1);
        end

        summary();
        $finish;
    end
endmodule